// File: doc/BRIEF.md
# Header-Driven Frame Pixel Sink

This block sits at the end of a pixel pipeline and takes in one frame at a time. It has two input streams, each with a valid/ready handshake. The header stream gives the frame dimensions as two 16-bit words: width first, then height. The pixel stream gives the pixel data. A two-state controller waits in its idle state until both header words are held in a small window. The window accepts the two words one by one and can hold them for as many cycles as needed. The controller then removes both words from the window together and loads a pixel budget with the product of width and height. After that it moves into its transfer state.

In the transfer state the block accepts pixels one per handshake. It forwards each pixel to a plain output port that has a valid strobe and an end-of-frame flag. Each pixel reduces the budget by one. The final pixel of a frame raises the end-of-frame flag, and the controller then returns to idle to wait for the next header. At any time, the stream that is not being consumed is held off with ready low. A header with zero width or zero height is removed from the window without producing any output, and the controller stays idle.

Top module: `frame_pixel_sink`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, clears the pixel budget and discards any header word held in the window. After reset, hdr_ready is 1, pix_ready is 0 and out_valid is 0.
- R2: In idle the header window accepts at most two words. Once two words are held, hdr_ready drops to 0 until they are consumed. Words may arrive with idle gaps between them.
- R3: pix_ready is 0 while the controller is idle. hdr_ready is 0 while it is transferring pixels. The two readies are never high together, and pixel valids offered while idle produce no output.
- R4: A new frame starts only when two header words are held. The first word accepted is the width and the second is the height. The frame's pixel count is width × height, formed as a 32-bit product. pix_ready rises in the second cycle after the second header word is accepted.
- R5: In the transfer state, each pixel handshake (pix_valid and pix_ready both high at a clock edge) forwards pix_data to out_data, with out_valid high for exactly the one cycle after that edge. A frame forwards exactly width × height pixels. Cycles with pix_valid low forward nothing.
- R6: out_last is 1 together with the final pixel of a frame and 0 with every other forwarded pixel.
- R7: After the final pixel is accepted, the controller is back in idle: hdr_ready is 1 and pix_ready is 0 from the next cycle on.
- R8: A header with width 0 or height 0 is consumed and produces no output. The controller stays idle and accepts the next header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header word offered |
| hdr_ready | output | 1 | Header word can be taken |
| hdr_data | input | DIM_W (16) | Header word: width first, then height |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken |
| pix_data | input | PIX_W (8) | Pixel value |
| out_valid | output | 1 | Forwarded pixel present |
| out_data | output | PIX_W (8) | Forwarded pixel value |
| out_last | output | 1 | Final pixel of the frame |

## Verification
The bench uses the default parameters: 16-bit dimensions, so the pixel count is 32 bits, and 8-bit pixels. Each pixel value is derived from a per-frame seed plus its index, so a dropped, repeated or reordered pixel changes the compared data. The frames are kept small so that the full length of each one can be checked. They include a single-pixel frame, in which the first pixel is also the last, and a 20×15 frame, which carries the budget past 255. Zero-width and zero-height headers are also sent. Header and pixel gaps, pixel valids offered while idle, and a reset that lands between the two header words cover the handshake and window corner cases.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} fps_state_e;
  localparam int HDR_DEPTH = 2;
endpackage

// File: rtl/fps_hdr_window.sv
module fps_hdr_window #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DIM_W-1:0] push_data,
  input  logic             pop,
  output logic             full,
  output logic [DIM_W-1:0] dim_a,
  output logic [DIM_W-1:0] dim_b
);
  import fps_pkg::*;
  localparam int IDX_W = $clog2(HDR_DEPTH + 1);

  logic [IDX_W-1:0] fill;
  logic [DIM_W-1:0] slot [HDR_DEPTH];

  // one register per header slot, written in arrival order
  for (genvar gi = 0; gi < HDR_DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot[gi] <= '0;
      else if (push && fill == IDX_W'(gi)) slot[gi] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (pop) fill <= '0;
    else if (push) fill <= fill + 1'b1;
  end

  assign full  = (fill == IDX_W'(HDR_DEPTH));
  assign dim_a = slot[0];
  assign dim_b = slot[1];

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> (fill < IDX_W'(HDR_DEPTH)));
  assert_pop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill == IDX_W'(HDR_DEPTH)));
endmodule

// File: rtl/fps_pixel_budget.sv
module fps_pixel_budget #(
  parameter int DIM_W = 16,
  localparam int CNT_W = 2 * DIM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             step,
  output logic             empty_frame,
  output logic             last
);
  function automatic logic [CNT_W-1:0] frame_area(input logic [DIM_W-1:0] w,
                                                  input logic [DIM_W-1:0] h);
    return CNT_W'(w) * CNT_W'(h);
  endfunction

  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst) remaining <= '0;
    else if (load) remaining <= frame_area(width, height);
    else if (step) remaining <= remaining - 1'b1;
  end

  assign empty_frame = (width == '0) || (height == '0);
  assign last        = (remaining == CNT_W'(1));

  assert_step_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    step |-> (remaining != '0));
  assert_load_not_step_R5: assert property (@(posedge clk) disable iff (rst)
    !(load && step));
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hdr_full,
  input  logic empty_frame,
  input  logic pix_valid,
  input  logic last,
  output logic frame_fire,
  output logic pix_fire,
  output logic hdr_open,
  output logic pix_open
);
  import fps_pkg::*;

  fps_state_e st, st_nx;

  assign frame_fire = (st == ST_IDLE) && hdr_full;
  assign pix_open   = (st == ST_XFER);
  assign pix_fire   = pix_open && pix_valid;
  assign hdr_open   = (st == ST_IDLE) && !hdr_full;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (frame_fire && !empty_frame) st_nx = ST_XFER;
      ST_XFER: if (pix_fire && last) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else st <= st_nx;
  end

  assert_ready_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(hdr_open && pix_open));
  assert_enter_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_fire && !empty_frame) |=> (st == ST_XFER));
  assert_return_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (pix_fire && last) |=> (st == ST_IDLE));
  assert_empty_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_fire && empty_frame) |=> (st == ST_IDLE));
endmodule

// File: rtl/frame_pixel_sink.sv
module frame_pixel_sink #(
  parameter int DIM_W = 16,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [DIM_W-1:0] hdr_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_last
);
  logic             hdr_push, hdr_full;
  logic [DIM_W-1:0] dim_w, dim_h;
  logic             frame_fire, pix_fire, empty_frame, last;

  assign hdr_push = hdr_valid && hdr_ready;

  fps_hdr_window #(.DIM_W(DIM_W)) u_window (
    .clk(clk), .rst(rst), .push(hdr_push), .push_data(hdr_data),
    .pop(frame_fire), .full(hdr_full), .dim_a(dim_w), .dim_b(dim_h)
  );

  fps_pixel_budget #(.DIM_W(DIM_W)) u_budget (
    .clk(clk), .rst(rst), .load(frame_fire), .width(dim_w), .height(dim_h),
    .step(pix_fire), .empty_frame(empty_frame), .last(last)
  );

  fps_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hdr_full(hdr_full), .empty_frame(empty_frame),
    .pix_valid(pix_valid), .last(last), .frame_fire(frame_fire),
    .pix_fire(pix_fire), .hdr_open(hdr_ready), .pix_open(pix_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= pix_fire;
      out_last  <= pix_fire && last;
      if (pix_fire) out_data <= pix_data;
    end
  end

  assert_out_follows_R5: assert property (@(posedge clk) disable iff (rst)
    pix_fire |=> out_valid);
  assert_no_spurious_out_R5: assert property (@(posedge clk) disable iff (rst)
    !pix_fire |=> !out_valid);
  assert_last_frees_header_R6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && hdr_ready));
endmodule

// File: tb/frame_pixel_sink_bench.sv
module frame_pixel_sink_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [15:0] hdr_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_data = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] cap_d [0:1023];
  logic       cap_l [0:1023];
  int         cap_n = 0;

  always #4 clk = ~clk;

  frame_pixel_sink u_frame_pixel_sink (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < 1024) begin
      cap_d[cap_n] = out_data;
      cap_l[cap_n] = out_last;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_hdr(input logic [15:0] v);
    hdr_valid = 1'b1;
    hdr_data  = v;
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic push_pix(input logic [7:0] v, input int gap);
    repeat (gap) @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = v;
    #1;
    while (!pix_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hdr_valid = 1'b0;
    pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    chk(hdr_ready == 1'b1, "R1 hdr_ready", hdr_ready, 1);
    chk(pix_ready == 1'b0, "R1 pix_ready", pix_ready, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  // R2 R3 R4 R5 R6 R7: one full frame
  task automatic t_frame(input int w, input int h, input int seed, input int gap,
                         input int hgap);
    int start, n, dbad, lbad;
    start = cap_n;
    n = w * h;
    @(negedge clk);
    push_hdr(16'(w));
    #1;
    chk(pix_ready == 1'b0, "R4 one word no start", pix_ready, 0);
    repeat (hgap) @(negedge clk);
    push_hdr(16'(h));
    #1;
    chk(!hdr_ready && !pix_ready, "R2 window full", {hdr_ready, pix_ready}, 0);
    @(negedge clk); #1;
    chk(pix_ready == 1'b1, "R4 xfer start", pix_ready, 1);
    chk(hdr_ready == 1'b0, "R3 hdr held", hdr_ready, 0);
    for (int i = 0; i < n; i++) push_pix(8'(seed + i), gap);
    repeat (3) @(negedge clk);
    #1;
    chk(hdr_ready && !pix_ready, "R7 back idle", {hdr_ready, pix_ready}, 2);
    chk(cap_n - start == n, "R5 pixel count", cap_n - start, n);
    dbad = 0; lbad = 0;
    for (int i = 0; i < n; i++) begin
      if (cap_d[start + i] != 8'(seed + i)) dbad++;
      if (cap_l[start + i] != (i == n - 1)) lbad++;
    end
    chk(dbad == 0, "R5 pixel data", dbad, 0);
    chk(lbad == 0, "R6 last flag", lbad, 0);
  endtask

  // R5 R6: single-pixel frame, output timing
  task automatic t_single();
    int start;
    start = cap_n;
    @(negedge clk);
    push_hdr(16'd1);
    push_hdr(16'd1);
    @(negedge clk);
    push_pix(8'hA5, 0);
    #1;
    chk(out_valid == 1'b1, "R5 one cycle latency", out_valid, 1);
    chk(out_data == 8'hA5, "R5 data", out_data, 8'hA5);
    chk(out_last == 1'b1, "R6 last on only pixel", out_last, 1);
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R5 single strobe", out_valid, 0);
    chk(hdr_ready == 1'b1, "R7 idle after last", hdr_ready, 1);
    chk(cap_n - start == 1, "R5 count 1x1", cap_n - start, 1);
  endtask

  // R8 R3: zero dimension headers, stray pixels while idle
  task automatic t_zero(input int w, input int h);
    int start;
    start = cap_n;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = 8'h3C;
    push_hdr(16'(w));
    push_hdr(16'(h));
    repeat (4) @(negedge clk);
    #1;
    chk(cap_n == start, "R8 no output", cap_n - start, 0);
    chk(pix_ready == 1'b0, "R3 pix held idle", pix_ready, 0);
    chk(hdr_ready == 1'b1, "R8 header consumed", hdr_ready, 1);
    pix_valid = 1'b0;
  endtask

  // R1: reset between header words drops the held word
  task automatic t_reset_partial();
    @(negedge clk);
    push_hdr(16'd9);
    do_reset();
    chk(hdr_ready == 1'b1, "R1 window cleared", hdr_ready, 1);
    t_frame(2, 2, 100, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(3, 2, 16, 0, 0);
    t_single();
    t_zero(0, 5);
    t_zero(7, 0);
    t_frame(4, 3, 200, 2, 3);
    t_frame(20, 15, 7, 0, 1);
    t_reset_partial();
    t_frame(1, 5, 50, 1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule